// File: doc/BRIEF.md
# Fixed-Frequency Quadrature Tone Generator

This block produces a digital sinusoid whose frequency is frozen when the design is built. A phase accumulator gains a constant step on every clock. The step is derived from the system clock rate and the wanted tone rate. The upper bits of the accumulator feed a fully pipelined shift-and-add vector rotator, and that rotator returns one sine and cosine pair per clock.

The accumulated angle is brought out in binary radians, delayed so that it lines up with the sample computed from it. A square wave at the tone rate is also brought out. A load strobe lets the host jump the phase to any value. The block can serve as a local oscillator for mixers, as a test-tone source, or as a phase reference that must stay coherent with a synthesized sample stream.

The amplitude is set by a real scale factor. The start vector of the rotator is pre-divided by the rotator gain, so the factor applies directly to the output.

Top module: `osc_cordic_fixed`

## Requirements
- R1: While the external reset equals `ARST_LEVEL` (default 0), all outputs are 0. Release is taken through a two-flop synchronizer, so the accumulator first steps on the third rising edge after release. Outputs stay 0 until the first accumulated phase has crossed the pipeline.
- R2: The accumulator width `ACC_W` is the smallest value from `WIDTH` to 48 for which round(2^ACC_W·OUT_HZ/SYS_HZ)·SYS_HZ/2^ACC_W differs from OUT_HZ by at most TOL·OUT_HZ. The step is that rounded value. The accumulator adds the step on every clock and wraps modulo 2^ACC_W.
- R3: `phase_out` carries the upper `WIDTH` bits of the accumulator as a two's-complement word in binary radians (2^WIDTH codes per turn), exactly ITER+2 clocks after the accumulator held that value.
- R4: At a rising edge where `phase_load` is 1, the accumulator takes `phase_value` in its upper `WIDTH` bits and zero in the lower bits, with no step added on that edge. Back-to-back loads each take effect.
- R5: `sine` and `cosine` equal A·sin and A·cos of 2π·`phase_out`/2^WIDTH within ±6 codes, on every clock, aligned with `phase_out`. A = round(MAG·(2^(WIDTH−1)−1)).
- R6: R5 holds in all four quadrants, including the codes 0x4000, 0x8000, 0xC000, 0x3FFF, 0x7FFF and 0xBFFF (for WIDTH=16). Angles in the second and third quadrants are folded by half a turn before rotation, so the rotator only ever sees angles within a quarter turn of zero.
- R7: `tone_clk` equals the most significant bit of `phase_out`. It is high over the half turn where that bit is set.
- R8: `sine` and `cosine` never take the most negative code. Rounded results are clamped to ±(2^(WIDTH−1)−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_in | input | 1 | Asynchronous reset, active at `ARST_LEVEL` |
| phase_load | input | 1 | Replace the accumulated phase on this edge |
| phase_value | input | WIDTH | Phase to load, binary radians |
| sine | output | WIDTH | Signed sine sample |
| cosine | output | WIDTH | Signed cosine sample |
| phase_out | output | WIDTH | Signed phase in binary radians, aligned with the samples |
| tone_clk | output | 1 | Square wave at the tone rate |

## Verification
The assertions place no constraint on `phase_load` or `phase_value`. Any value can be loaded on any edge, so the load, step and fold properties must hold for arbitrary stimulus. The bound on the folded angle relies only on the accumulator contents, and every code is legal there. The bench therefore loads the quadrant edges, loads on consecutive edges, runs long free stretches so that the accumulator wraps, and asserts reset in the middle of a run. This drives the rotator through its full angular range without any input filtering.

// File: rtl/osc_pkg.sv
package osc_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // smallest accumulator width whose rounded step meets the relative tolerance
  function automatic int acc_width(real sys_hz, real out_hz, real tol, int min_w, int max_w);
    int  found;
    real scale;
    real step;
    found = max_w;
    for (int n = max_w; n >= min_w; n--) begin
      scale = 2.0 ** n;
      step  = $floor(scale * out_hz / sys_hz + 0.5);
      if (step > 0.0) begin
        if ((step * sys_hz / scale - out_hz <= tol * out_hz) &&
            (out_hz - step * sys_hz / scale <= tol * out_hz))
          found = n;
      end
    end
    return found;
  endfunction

  function automatic longint phase_step(real sys_hz, real out_hz, int acc_w);
    return longint'($floor((2.0 ** acc_w) * out_hz / sys_hz + 0.5));
  endfunction

  // length growth of the rotated vector after a number of micro-rotations
  function automatic real rotator_gain(int iters);
    real g;
    g = 1.0;
    for (int i = 0; i < iters; i++) g = g * $sqrt(1.0 + 2.0 ** (-2 * i));
    return g;
  endfunction

  // arctangent of 2^-i in units where one turn spans 2^bits
  function automatic longint atan_units(int i, int bits);
    return longint'($floor($atan(2.0 ** (-i)) / TWO_PI * (2.0 ** bits) + 0.5));
  endfunction

endpackage

// File: rtl/osc_rst_sync.sv
module osc_rst_sync #(
  parameter logic ACTIVE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic arst_in,
  output logic rst_n
);
  logic       rst_req;
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign rst_req = (arst_in == ACTIVE_LEVEL);

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or posedge rst_req) begin
    if (rst_req) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/osc_phase_acc.sv
module osc_phase_acc #(
  parameter int     ACC_W = 18,
  parameter int     WIDTH = 16,
  parameter longint STEP  = 2097
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] phase_top
);
  localparam int             LOW_W  = ACC_W - WIDTH;
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  generate
    if (LOW_W > 0) begin : g_wide
      always_comb begin
        if (load_en) acc_d = {load_val, {LOW_W{1'b0}}};
        else         acc_d = acc_q + STEP_V;
      end
    end else begin : g_exact
      always_comb begin
        if (load_en) acc_d = load_val;
        else         acc_d = acc_q + STEP_V;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign phase_top = acc_q[ACC_W-1 -: WIDTH];

  AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (phase_top == $past(load_val)));  // R4

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (acc_q == ACC_W'($past(acc_q) + STEP_V)));  // R2
endmodule

// File: rtl/osc_rot_stage.sv
module osc_rot_stage #(
  parameter int     XW    = 20,
  parameter int     ZW    = 19,
  parameter int     SHIFT = 0,
  parameter longint TURN  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic signed [ZW-1:0] ROT = ZW'(TURN);

  logic signed [XW-1:0] x_sh;
  logic signed [XW-1:0] y_sh;
  logic signed [XW-1:0] x_d;
  logic signed [XW-1:0] y_d;
  logic signed [ZW-1:0] z_d;

  always_comb begin
    x_sh = x_i >>> SHIFT;
    y_sh = y_i >>> SHIFT;
    if (!z_i[ZW-1]) begin
      x_d = x_i - y_sh;
      y_d = y_i + x_sh;
      z_d = z_i - ROT;
    end else begin
      x_d = x_i + y_sh;
      y_d = y_i - x_sh;
      z_d = z_i + ROT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      x_o <= x_d;
      y_o <= y_d;
      z_o <= z_d;
    end
  end
endmodule

// File: rtl/osc_cordic_fixed.sv
module osc_cordic_fixed #(
  parameter real  SYS_HZ     = 125.0e6,
  parameter real  OUT_HZ     = 1.0e6,
  parameter real  TOL        = 1.0e-4,
  parameter int   WIDTH      = 16,
  parameter int   ITER       = 16,
  parameter real  MAG        = 0.9,
  parameter int   GUARD      = 3,
  parameter logic ARST_LEVEL = 1'b0
) (
  input  logic                    clk,
  input  logic                    arst_in,
  input  logic                    phase_load,
  input  logic [WIDTH-1:0]        phase_value,
  output logic signed [WIDTH-1:0] sine,
  output logic signed [WIDTH-1:0] cosine,
  output logic signed [WIDTH-1:0] phase_out,
  output logic                    tone_clk
);
  localparam int     ACC_W  = osc_pkg::acc_width(SYS_HZ, OUT_HZ, TOL, WIDTH, 48);
  localparam longint STEP   = osc_pkg::phase_step(SYS_HZ, OUT_HZ, ACC_W);
  localparam int     XW     = WIDTH + 1 + GUARD;
  localparam int     ZW     = WIDTH + GUARD;
  localparam int     LAT    = ITER + 2;
  localparam longint PEAK   = longint'($floor(MAG * (2.0 ** (WIDTH - 1) - 1.0) + 0.5));
  localparam real    GAIN   = osc_pkg::rotator_gain(ITER);
  localparam longint START  = longint'($floor(real'(PEAK) * (2.0 ** GUARD) / GAIN + 0.5));
  localparam logic signed [XW-1:0] X_START = XW'(START);
  localparam logic signed [ZW-1:0] QUARTER = ZW'(longint'(1) <<< (ZW - 2));
  localparam logic signed [XW-1:0] LIM_HI  = XW'((longint'(1) <<< (WIDTH - 1)) - 1);
  localparam logic signed [XW-1:0] LIM_LO  = -LIM_HI;
  localparam logic signed [XW-1:0] HALF_LSB = XW'(longint'(1) <<< (GUARD - 1));

  logic             rst_n;
  logic [WIDTH-1:0] acc_top;

  osc_rst_sync #(.ACTIVE_LEVEL(ARST_LEVEL)) u_rst (
    .clk     (clk),
    .arst_in (arst_in),
    .rst_n   (rst_n)
  );

  osc_phase_acc #(.ACC_W(ACC_W), .WIDTH(WIDTH), .STEP(STEP)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (phase_load),
    .load_val  (phase_value),
    .phase_top (acc_top)
  );

  // quadrant fold: second and third quadrant move by half a turn, start vector flips
  logic                 fold;
  logic [WIDTH-1:0]     ang_f;
  logic signed [XW-1:0] x0_d;
  logic signed [ZW-1:0] z0_d;
  logic signed [XW-1:0] xs [ITER+1];
  logic signed [XW-1:0] ys [ITER+1];
  logic signed [ZW-1:0] zs [ITER+1];

  always_comb begin
    fold  = acc_top[WIDTH-1] ^ acc_top[WIDTH-2];
    ang_f = fold ? {~acc_top[WIDTH-1], acc_top[WIDTH-2:0]} : acc_top;
    x0_d  = fold ? -X_START : X_START;
    z0_d  = {ang_f, {GUARD{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs[0] <= '0;
      ys[0] <= '0;
      zs[0] <= '0;
    end else begin
      xs[0] <= x0_d;
      ys[0] <= '0;
      zs[0] <= z0_d;
    end
  end

  AST_FOLD_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    (zs[0] >= -QUARTER) && (zs[0] < QUARTER));  // R6

  generate
    for (genvar i = 0; i < ITER; i++) begin : g_stage
      osc_rot_stage #(
        .XW    (XW),
        .ZW    (ZW),
        .SHIFT (i),
        .TURN  (osc_pkg::atan_units(i, ZW))
      ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .x_i   (xs[i]),
        .y_i   (ys[i]),
        .z_i   (zs[i]),
        .x_o   (xs[i+1]),
        .y_o   (ys[i+1]),
        .z_o   (zs[i+1])
      );
    end
  endgenerate

  // rounding and clamping of the rotator result
  logic signed [XW-1:0]    cos_r;
  logic signed [XW-1:0]    sin_r;
  logic signed [WIDTH-1:0] cos_d;
  logic signed [WIDTH-1:0] sin_d;

  always_comb begin
    cos_r = (xs[ITER] + HALF_LSB) >>> GUARD;
    sin_r = (ys[ITER] + HALF_LSB) >>> GUARD;
    if (cos_r > LIM_HI)      cos_d = WIDTH'(LIM_HI);
    else if (cos_r < LIM_LO) cos_d = WIDTH'(LIM_LO);
    else                     cos_d = WIDTH'(cos_r);
    if (sin_r > LIM_HI)      sin_d = WIDTH'(LIM_HI);
    else if (sin_r < LIM_LO) sin_d = WIDTH'(LIM_LO);
    else                     sin_d = WIDTH'(sin_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sine   <= '0;
      cosine <= '0;
    end else begin
      sine   <= sin_d;
      cosine <= cos_d;
    end
  end

  // angle delay line matching the rotator depth
  logic [WIDTH-1:0] ang_q [LAT+1];
  assign ang_q[0] = acc_top;

  generate
    for (genvar k = 0; k < LAT; k++) begin : g_align
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ang_q[k+1] <= '0;
        else        ang_q[k+1] <= ang_q[k];
      end
    end
  endgenerate

  assign phase_out = ang_q[LAT];
  assign tone_clk  = ang_q[LAT][WIDTH-1];

  AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sine != {1'b1, {(WIDTH-1){1'b0}}}) && (cosine != {1'b1, {(WIDTH-1){1'b0}}}));  // R8
endmodule

// File: tb/osc_cordic_fixed_bench.sv
module osc_cordic_fixed_bench;
  localparam int  W    = 16;
  localparam int  IT   = 16;
  localparam real FS   = 125.0e6;
  localparam real FO   = 1.0e6;
  localparam real TOLR = 1.0e-4;
  localparam real MAGR = 0.9;
  localparam int  LAT  = IT + 2;
  localparam int  SLACK = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                arst_in;
  logic                ld;
  logic [W-1:0]        pv;
  logic signed [W-1:0] sine;
  logic signed [W-1:0] cosine;
  logic signed [W-1:0] phase_out;
  logic                tone_clk;

  osc_cordic_fixed #(
    .SYS_HZ(FS), .OUT_HZ(FO), .TOL(TOLR), .WIDTH(W), .ITER(IT),
    .MAG(MAGR), .GUARD(3), .ARST_LEVEL(1'b0)
  ) u_osc_cordic_fixed (
    .clk(clk), .arst_in(arst_in), .phase_load(ld), .phase_value(pv),
    .sine(sine), .cosine(cosine), .phase_out(phase_out), .tone_clk(tone_clk)
  );

  int     total = 0;
  int     bad   = 0;
  int     accw;
  longint stepv;
  longint mask;
  longint peak;
  longint acc_m;
  int     sync_cnt;
  longint hist[$];
  string  tag;

  function automatic int width_for_tol();
    int res = 48;
    for (int n = 48; n >= W; n--) begin
      real sc = 2.0 ** n;
      real st = $floor(sc * FO / FS + 0.5);
      real er = st * FS / sc - FO;
      if (er < 0.0) er = -er;
      if (st > 0.0 && er <= TOLR * FO) res = n;
    end
    return res;
  endfunction

  task automatic check(string req, string what, longint act, longint exp, int slack);
    longint d = act - exp;
    total++;
    if (d < 0) d = -d;
    if (d > slack) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    acc_m = 0;
    sync_cnt = 0;
    hist.delete();
    for (int i = 0; i < LAT; i++) hist.push_back(-1);
  endtask

  task automatic model_edge(bit in_reset, bit l, logic [W-1:0] p);
    if (in_reset) model_reset();
    else if (sync_cnt < 2) sync_cnt++;
    else begin
      hist.push_back(acc_m);
      void'(hist.pop_front());
      if (l) acc_m = longint'(p) << (accw - W);
      else   acc_m = (acc_m + stepv) & mask;
    end
  endtask

  task automatic compare();
    longint e = hist[0];
    if (e < 0) begin
      check("R1", "sine", sine, 0, 0);
      check("R1", "cosine", cosine, 0, 0);
      check("R1", "phase_out", phase_out, 0, 0);
      check("R1", "tone_clk", tone_clk, 0, 0);
    end else begin
      longint a  = e >> (accw - W);
      longint sa = (a >= (longint'(1) << (W - 1))) ? a - (longint'(1) << W) : a;
      real    th = 6.283185307179586 * real'(sa) / (2.0 ** W);
      longint es = longint'($floor(real'(peak) * $sin(th) + 0.5));
      longint ec = longint'($floor(real'(peak) * $cos(th) + 0.5));
      string  rq = (tag == "R6") ? "R6" : "R5";
      check((tag == "R4") ? "R4" : ((tag == "R2") ? "R2" : "R3"), "phase_out", phase_out, sa, 0);
      check("R7", "tone_clk", tone_clk, (a >> (W - 1)) & 1, 0);
      check(rq, "sine", sine, es, SLACK);
      check(rq, "cosine", cosine, ec, SLACK);
      total++;
      if (sine == -(longint'(1) << (W - 1)) || cosine == -(longint'(1) << (W - 1))) begin
        bad++;
        $display("FAIL R8 clamp actual=%0d/%0d expected=not %0d", sine, cosine, -(longint'(1) << (W - 1)));
      end
    end
  endtask

  task automatic tick(bit l, logic [W-1:0] p);
    ld = l;
    pv = p;
    @(posedge clk);
    model_edge(arst_in == 1'b0, l, p);
    @(negedge clk);
    compare();
    ld = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] corners [7];
    accw  = width_for_tol();
    stepv = longint'($floor((2.0 ** accw) * FO / FS + 0.5));
    mask  = (longint'(1) << accw) - 1;
    peak  = longint'($floor(MAGR * (2.0 ** (W - 1) - 1.0) + 0.5));
    corners = '{16'h4000, 16'h8000, 16'hC000, 16'h3FFF, 16'h7FFF, 16'hBFFF, 16'h0000};

    arst_in = 1'b0;
    ld = 1'b0;
    pv = '0;
    model_reset();
    tag = "R1";
    @(negedge clk);
    compare();
    repeat (3) tick(0, '0);

    // R1 R2: release, pipeline fill, free running with wrap
    arst_in = 1'b1;
    tag = "R2";
    repeat (LAT + 4) tick(0, '0);
    repeat (400) tick(0, '0);

    // R4: single and back-to-back loads
    tag = "R4";
    tick(1, 16'h1234);
    repeat (LAT + 8) tick(0, '0);
    tick(1, 16'hFFF0);
    tick(1, 16'h0100);
    tick(1, 16'h9ABC);
    repeat (LAT + 8) tick(0, '0);

    // R6: quadrant boundaries
    tag = "R6";
    foreach (corners[i]) begin
      tick(1, corners[i]);
      repeat (LAT + 3) tick(0, '0);
    end

    // R5: long free run across many turns
    tag = "R5";
    repeat (1500) tick(0, '0);

    // R1: reset in the middle of a run
    arst_in = 1'b0;
    #1;
    model_reset();
    tag = "R1";
    compare();
    repeat (2) tick(1, 16'h5555);
    @(negedge clk);
    arst_in = 1'b1;
    tag = "R2";
    repeat (LAT + 200) tick(0, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule